// File: doc/BRIEF.md
# Interrupt-capable GPIO bank

This block is one bank of general-purpose pins placed behind a small memory-mapped register bus. Software sets an output value and an output enable per pin, reads back the synchronised pin level, and chooses per pin how a change or a level on that pin should raise an interrupt. Every register holds one bit per pin, and pin n always uses bit n.

Pad levels pass through a two-stage synchroniser before anything else sees them. Edge sensing compares the synchronised sample with the one taken a cycle earlier. Each pin keeps a sticky pending bit. Software reads that bit raw, or gated by a per-pin enable, and clears it by writing ones. One interrupt line leaves the block and is high whenever any enabled pin is pending. Reads return data one cycle after the read strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, pad_oe and pad_out are zero and irq is low, so every pin is an input with falling-edge sense and its interrupt disabled.
- R2: The data-out register (offset 0x04) and the output-enable register (offset 0x08) read back what was written. pad_oe follows the enable register, and pad_out carries a data-out bit only where that pin's enable bit is 1 (zero elsewhere).
- R3: The data-in register (offset 0x00) reads the pad level after two synchroniser flops. Writes to data-in, raw status (0x1C) and masked status (0x20) have no effect.
- R4: With sense-type bit (0x0C) at 0 and dual bit (0x10) at 0, the pending bit in raw status (0x1C) sets on a rising pad edge when the polarity bit (0x14) is 1 and on a falling edge when it is 0. The edge of the other direction does not set it.
- R5: With sense-type 0 and dual bit 1, both rising and falling edges set the pending bit, whatever the polarity bit holds.
- R6: With sense-type bit 1, the pending bit sets while the synchronised pad equals the polarity bit (1 = high active, 0 = low active). A clear does not remove it while that level persists, and edges do not set it.
- R7: Writing a 1 to a bit of the clear register (0x24) clears that pin's pending bit. Writing 0 leaves it unchanged, and the clear register reads zero.
- R8: Masked status (0x20) equals raw status AND the enable register (0x18), where 1 enables the pin. irq is the OR of masked status.
- R9: When an edge that sets a pin's pending bit and a clear of that bit land in the same cycle, the bit stays set, while other bits in the same clear write are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pad_in | input | N_PINS (32) | Asynchronous pad levels |
| pad_out | output | N_PINS (32) | Output value to the pads |
| pad_oe | output | N_PINS (32) | Per-pin output drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to create is the collision of a fresh edge and a clear write on the same bit in the same cycle. It needs the pad change to be timed against the three register stages between the pad and the pending bit. The bench changes the pad on a falling clock edge and lets exactly two rising edges pass. It then drives the clear write so that it is sampled on the third edge, together with a second, already-pending bit that must clear. Level sensing that survives a clear is reached by keeping the pad at the active level across the clear write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_DIN   = 8'h00;
   localparam logic [OFS_W-1:0] OFS_DOUT  = 8'h04;
   localparam logic [OFS_W-1:0] OFS_OE    = 8'h08;
   localparam logic [OFS_W-1:0] OFS_TYPE  = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_DUAL  = 8'h10;
   localparam logic [OFS_W-1:0] OFS_POL   = 8'h14;
   localparam logic [OFS_W-1:0] OFS_MASK  = 8'h18;
   localparam logic [OFS_W-1:0] OFS_RAW   = 8'h1C;
   localparam logic [OFS_W-1:0] OFS_MSTAT = 8'h20;
   localparam logic [OFS_W-1:0] OFS_CLR   = 8'h24;

   typedef enum logic [1:0] {
      SENSE_EDGE_ONE = 2'd0,
      SENSE_EDGE_TWO = 2'd1,
      SENSE_LEVEL    = 2'd2
   } sense_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_bank_pkg::*;
#(
   parameter int unsigned N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] level,
   input  logic [N_PINS-1:0] is_level,
   input  logic [N_PINS-1:0] both_edges,
   input  logic [N_PINS-1:0] polarity,
   input  logic [N_PINS-1:0] clr,
   output logic [N_PINS-1:0] hit,
   output logic [N_PINS-1:0] pending
);
   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic   prev_q;
      logic   rise, fall;
      sense_e mode;

      assign rise = level[p] & ~prev_q;
      assign fall = ~level[p] & prev_q;
      assign mode = is_level[p]   ? SENSE_LEVEL :
                    both_edges[p] ? SENSE_EDGE_TWO : SENSE_EDGE_ONE;

      always_comb begin
         unique case (mode)
            SENSE_LEVEL:    hit[p] = (level[p] == polarity[p]);
            SENSE_EDGE_TWO: hit[p] = rise | fall;
            default:        hit[p] = polarity[p] ? rise : fall;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q     <= 1'b0;
            pending[p] <= 1'b0;
         end else begin
            prev_q     <= level[p];
            pending[p] <= (pending[p] & ~clr[p]) | hit[p];
         end
      end
   end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned N_PINS      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_oe,
   output logic              irq
);
   localparam int unsigned PAD_W = DATA_W - N_PINS;

   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_irq_bank: N_PINS must be 1..DATA_W");
   end
   if (ADDR_W < 6 || ADDR_W > OFS_W) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must be 6..8");
   end

   logic [N_PINS-1:0] dout_q, oe_q, type_q, dual_q, pol_q, mask_q;
   logic [N_PINS-1:0] din_sync, raw_stat, irq_hit, clr_vec, mstat;
   logic [OFS_W-1:0]  ofs;
   logic [N_PINS-1:0] wbits;

   assign ofs   = OFS_W'(bus_addr);
   assign wbits = bus_wdata[N_PINS-1:0];

   gpio_in_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= '0;
         type_q <= '0;
         dual_q <= '0;
         pol_q  <= '0;
         mask_q <= '0;
      end else if (bus_wr) begin
         case (ofs)
            OFS_DOUT: dout_q <= wbits;
            OFS_OE:   oe_q   <= wbits;
            OFS_TYPE: type_q <= wbits;
            OFS_DUAL: dual_q <= wbits;
            OFS_POL:  pol_q  <= wbits;
            OFS_MASK: mask_q <= wbits;
            default: ;
         endcase
      end
   end

   assign clr_vec = (bus_wr && ofs == OFS_CLR) ? wbits : '0;

   gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
      .clk(clk), .rst_n(rst_n), .level(din_sync), .is_level(type_q),
      .both_edges(dual_q), .polarity(pol_q), .clr(clr_vec),
      .hit(irq_hit), .pending(raw_stat)
   );

   assign mstat = raw_stat & mask_q;

   logic [N_PINS-1:0] rd_sel;
   always_comb begin
      case (ofs)
         OFS_DIN:   rd_sel = din_sync;
         OFS_DOUT:  rd_sel = dout_q;
         OFS_OE:    rd_sel = oe_q;
         OFS_TYPE:  rd_sel = type_q;
         OFS_DUAL:  rd_sel = dual_q;
         OFS_POL:   rd_sel = pol_q;
         OFS_MASK:  rd_sel = mask_q;
         OFS_RAW:   rd_sel = raw_stat;
         OFS_MSTAT: rd_sel = mstat;
         default:   rd_sel = '0;
      endcase
   end

   logic [DATA_W-1:0] rd_ext;
   if (PAD_W > 0) begin : g_ext
      assign rd_ext = {{PAD_W{1'b0}}, rd_sel};
   end else begin : g_noext
      assign rd_ext = rd_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_ext;
   end

   assign pad_out = dout_q & oe_q;
   assign pad_oe  = oe_q;
   assign irq     = |mstat;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int unsigned N_PINS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_PINS-1:0] stat,
   input logic [N_PINS-1:0] hit,
   input logic [N_PINS-1:0] clr,
   input logic [N_PINS-1:0] mask,
   input logic [N_PINS-1:0] pad_out,
   input logic [N_PINS-1:0] pad_oe,
   input logic              irq
);
   // R8: the interrupt line follows enabled pending bits
   a_r8_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(stat & mask));

   // R2: no pad value without drive enable
   a_r2_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R4 R5 R6: a pending bit appears only after a detected event
   a_r4_set_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & ~$past(stat) & ~$past(hit)) == '0);

   // R9: a detected event always leaves the bit set, even under clear
   a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit) & ~stat) == '0);

   // R7: a clear with no event removes the bit
   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) & ~$past(hit) & stat) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PINS(N_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .stat(raw_stat), .hit(irq_hit),
   .clr(clr_vec), .mask(mask_q), .pad_out(pad_out), .pad_oe(pad_oe),
   .irq(irq)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
   localparam int N = 32;
   localparam logic [7:0] A_DIN = 8'h00, A_DOUT = 8'h04, A_OE = 8'h08,
      A_TYPE = 8'h0C, A_DUAL = 8'h10, A_POL = 8'h14, A_MASK = 8'h18,
      A_RAW = 8'h1C, A_MST = 8'h20, A_CLR = 8'h24;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pad_in = '0, pad_out, pad_oe;
   logic irq;

   int tests = 0, fails = 0;

   typedef struct { logic [31:0] exp; string tag; } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   gpio_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // monitor: compares read data one cycle after each strobe
   always @(posedge clk) begin
      if (bus_rd) begin
         #1;
         if (sb.size() == 0) begin
            tests++; fails++;
            $display("FAIL %s: read with empty scoreboard", "R1");
         end else begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (bus_rdata !== e.exp) begin
               fails++;
               $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag;
      sb.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
      tests++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic set_pad(input logic [N-1:0] v);
      @(negedge clk);
      pad_in = v;
      idle(5);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      chk({31'b0, irq}, 0, "R1 irq");
      chk(pad_oe, 0, "R1 pad_oe");
      chk(pad_out, 0, "R1 pad_out");
      rd(A_DOUT, 0, "R1 dout"); rd(A_OE, 0, "R1 oe"); rd(A_TYPE, 0, "R1 type");
      rd(A_DUAL, 0, "R1 dual"); rd(A_POL, 0, "R1 pol"); rd(A_MASK, 0, "R1 mask");
      rd(A_RAW, 0, "R1 raw"); rd(A_MST, 0, "R1 mstat"); rd(A_DIN, 0, "R1 din");

      // R2 output registers and drive gating
      wr(A_DOUT, 32'hA5A5_0F0F);
      wr(A_OE, 32'hFFFF_0000);
      rd(A_DOUT, 32'hA5A5_0F0F, "R2 dout");
      rd(A_OE, 32'hFFFF_0000, "R2 oe");
      chk(pad_oe, 32'hFFFF_0000, "R2 pad_oe");
      chk(pad_out, 32'hA5A5_0000, "R2 pad_out");

      // R3 input path and read-only registers
      set_pad(32'h1234_5678);
      rd(A_DIN, 32'h1234_5678, "R3 din");
      wr(A_DIN, 32'h0);
      rd(A_DIN, 32'h1234_5678, "R3 din write ignored");
      rd(A_RAW, 0, "R4 rising not seen by falling sense");
      wr(A_RAW, 32'hFFFF_FFFF);
      wr(A_MST, 32'hFFFF_FFFF);
      rd(A_RAW, 0, "R3 raw write ignored");

      // R4 default falling sense, then R7 partial clear
      set_pad(0);
      rd(A_RAW, 32'h1234_5678, "R4 falling");
      wr(A_CLR, 32'h0000_5678);
      rd(A_RAW, 32'h1234_0000, "R7 zeros keep bits");
      rd(A_CLR, 0, "R7 clear reads zero");
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_RAW, 0, "R7 clear all");

      // R4 rising polarity
      wr(A_POL, 32'h0000_00FF);
      set_pad(32'h0000_0F0F);
      rd(A_RAW, 32'h0000_000F, "R4 rising");
      set_pad(0);
      rd(A_RAW, 32'h0000_0F0F, "R4 mixed polarity");
      wr(A_CLR, 32'hFFFF_FFFF);
      wr(A_POL, 0);

      // R5 dual edge
      wr(A_DUAL, 32'h00F0_0000);
      wr(A_POL, 32'h0080_0000);
      set_pad(32'h00B0_0000);
      rd(A_RAW, 32'h00B0_0000, "R5 rise both");
      wr(A_CLR, 32'hFFFF_FFFF);
      set_pad(0);
      rd(A_RAW, 32'h00B0_0000, "R5 fall both");
      wr(A_CLR, 32'hFFFF_FFFF);
      wr(A_DUAL, 0);
      wr(A_POL, 0);
      rd(A_RAW, 0, "R5 cleared");

      // R6 level sense: bit28 high active, bit29 low active
      wr(A_POL, 32'h1000_0000);
      wr(A_TYPE, 32'h3000_0000);
      idle(2);
      rd(A_RAW, 32'h2000_0000, "R6 low level");
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_RAW, 32'h2000_0000, "R6 persists over clear");
      set_pad(32'h3000_0000);
      rd(A_RAW, 32'h3000_0000, "R6 high level");
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_RAW, 32'h1000_0000, "R6 inactive clears");
      set_pad(0);
      wr(A_TYPE, 0);
      wr(A_POL, 0);
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_RAW, 0, "R6 restored");

      // R8 mask and irq
      set_pad(32'h1);
      set_pad(0);
      rd(A_RAW, 32'h1, "R8 raw");
      rd(A_MST, 0, "R8 masked off");
      chk({31'b0, irq}, 0, "R8 irq masked");
      wr(A_MASK, 32'h1);
      rd(A_MST, 32'h1, "R8 masked on");
      chk({31'b0, irq}, 1, "R8 irq on");
      wr(A_MASK, 32'h2);
      rd(A_MST, 0, "R8 other pin mask");
      chk({31'b0, irq}, 0, "R8 irq other");
      wr(A_MASK, 32'h3);
      wr(A_CLR, 32'h1);
      chk({31'b0, irq}, 0, "R8 irq after clear");

      // R9 edge and clear in the same cycle
      set_pad(32'h3);
      set_pad(32'h2);
      rd(A_RAW, 32'h1, "R9 setup");
      @(negedge clk);
      pad_in = 32'h0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_addr = A_CLR; bus_wdata = 32'h3; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(A_RAW, 32'h2, "R9 edge wins, other bit cleared");
      chk({31'b0, irq}, 1, "R9 irq");

      idle(4);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #100000;
      tests++; fails++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule